// File: doc/BRIEF.md
# Video Test Pattern Source

This block sits behind a video timing generator and fills each active pixel with 24-bit RGB888 test content. Two static control bits pick the content. The first choice is a two-colour checkerboard with separately sized tiles for each colour and a programmable band height. The second is a grey ramp that restarts on every line. With both bits clear, the block forwards the upstream video. The block never alters the timing: the data-enable, horizontal sync and vertical sync signals are re-timed by the same single register stage as the pixel data, so all four outputs stay aligned.

The stream runs free with no back-pressure. The data-enable input acts as the valid qualifier of the incoming stream and `de_out` qualifies the outgoing one. There is no ready signal, because a raster timing generator cannot pause, and every active pixel produces exactly one output pixel one cycle later. A frame starts on the rising edge of `vs_in`. A line starts on the first cycle in which `de_in` is high, and it ends on the first cycle in which `de_in` is low again.

Top module: `pg_pattern_src`

## Requirements
- R1: While `rst_n` is low, and on the first output cycle after reset, `pix_out`, `de_out`, `hs_out` and `vs_out` are all zero.
- R2: With `chk_en`=1, every active pixel is either `color_a` or `color_b`. Along a line, runs of `tile_size[7:0]` pixels of A alternate with runs of `tile_size[15:8]` pixels of B, and each line begins with a full run of its starting colour.
- R3: The starting colour of a line is A for the first `tile_size[23:16]` active lines of a frame. It then changes after every further `tile_size[23:16]` active lines.
- R4: A rising edge of `vs_in` returns the line starting colour to A and restarts the line count for the band, whatever state the previous frame left.
- R5: A zero in any of the three size bytes behaves exactly like the value 1.
- R6: With `grad_en`=1 and `chk_en`=0, all three 8-bit channels of an active pixel carry the same value. For the pixel at position x (counted from 0 at line start), that value is (x * `grad_step`) mod 256.
- R7: With both enable bits clear, each active output pixel equals `vid_in` from the cycle before.
- R8: With both enable bits set, the checkerboard is produced.
- R9: `pix_out` is zero in every cycle where `de_out` is low.
- R10: `de_out`, `hs_out` and `vs_out` equal `de_in`, `hs_in` and `vs_in` delayed by exactly one clock. `pix_out` belongs to the input sample taken on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Selects checkerboard (wins when both set) |
| grad_en | input | 1 | Selects grey ramp |
| color_a | input | 24 | Checkerboard colour A, RGB888 |
| color_b | input | 24 | Checkerboard colour B, RGB888 |
| tile_size | input | 24 | [7:0] A tile width, [15:8] B tile width, [23:16] band height in lines |
| grad_step | input | 8 | Ramp increment per active pixel |
| de_in | input | 1 | Data enable from timing generator |
| hs_in | input | 1 | Horizontal sync from timing generator |
| vs_in | input | 1 | Vertical sync, rising edge starts a frame |
| vid_in | input | 24 | Upstream pixel data |
| pix_out | output | 24 | Output pixel, RGB888 |
| de_out | output | 1 | Delayed data enable |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |

## Verification
Each configuration drives two whole frames of seven lines and checks every cycle of those frames. Unequal A and B widths show whether the tile counter reloads from the width of the colour it is leaving. A band height of two over seven lines leaves the second frame mid-band, so a missing frame-start reset shows up at once. A zero-size setting is compared with a width-one expectation, and two ramp steps are run over lines long enough to wrap the 8-bit value. A passthrough run with position-coded upstream data, a run with both enable bits set, and a reset asserted during active video round out the content and priority checks.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 3 * CH_W;

  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_CHK  = 2'd1,
    SRC_RAMP = 2'd2
  } src_e;

  typedef struct packed {
    logic line_start;
    logic line_end;
    logic frame_start;
  } raster_ev_t;
endpackage

// File: rtl/pg_raster_events.sv
module pg_raster_events
  import pg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       de_in,
  input  logic       hs_in,
  input  logic       vs_in,
  output raster_ev_t ev,
  output logic       de_q,
  output logic       hs_q,
  output logic       vs_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q <= 1'b0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      de_q <= de_in;
      hs_q <= hs_in;
      vs_q <= vs_in;
    end
  end

  always_comb begin
    ev.line_start  = de_in & ~de_q;
    ev.line_end    = ~de_in & de_q;
    ev.frame_start = vs_in & ~vs_q;
  end
endmodule

// File: rtl/pg_tile_gen.sv
module pg_tile_gen
  import pg_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_in,
  input  raster_ev_t        ev,
  input  logic [SIZE_W-1:0] width_a,
  input  logic [SIZE_W-1:0] width_b,
  input  logic [SIZE_W-1:0] band_h,
  output logic              use_b
);
  localparam int EXT_W = SIZE_W + 1;

  logic [SIZE_W-1:0] run_cnt;
  logic              col_q;
  logic [SIZE_W-1:0] line_cnt;
  logic              band_q;

  logic [SIZE_W-1:0] eff_a, eff_b, eff_h, cur_w;
  logic              run_done;
  logic [EXT_W-1:0]  line_next;

  function automatic logic [SIZE_W-1:0] clamp1(input logic [SIZE_W-1:0] v);
    return (v == '0) ? SIZE_W'(1) : v;
  endfunction

  always_comb begin
    eff_a     = clamp1(width_a);
    eff_b     = clamp1(width_b);
    eff_h     = clamp1(band_h);
    cur_w     = col_q ? eff_b : eff_a;
    run_done  = (run_cnt >= cur_w);
    line_next = EXT_W'(line_cnt) + EXT_W'(1);
    if (ev.line_start)  use_b = band_q;
    else if (run_done)  use_b = ~col_q;
    else                use_b = col_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      col_q   <= 1'b0;
    end else if (de_in) begin
      col_q <= use_b;
      if (ev.line_start || run_done) run_cnt <= SIZE_W'(1);
      else                           run_cnt <= run_cnt + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      band_q   <= 1'b0;
    end else if (ev.frame_start) begin
      line_cnt <= '0;
      band_q   <= 1'b0;
    end else if (ev.line_end) begin
      if (line_next >= EXT_W'(eff_h)) begin
        line_cnt <= '0;
        band_q   <= ~band_q;
      end else begin
        line_cnt <= line_next[SIZE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pg_ramp_gen.sv
module pg_ramp_gen
  import pg_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_in,
  input  raster_ev_t        ev,
  input  logic [STEP_W-1:0] step,
  output logic [STEP_W-1:0] level
);
  logic [STEP_W-1:0] acc_q;

  always_comb begin
    if (ev.line_start) level = '0;
    else               level = acc_q + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (de_in) acc_q <= level;
  end
endmodule

// File: rtl/pg_pattern_src.sv
module pg_pattern_src
  import pg_pkg::*;
#(
  parameter int CHAN_W = CH_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chk_en,
  input  logic                grad_en,
  input  logic [3*CHAN_W-1:0] color_a,
  input  logic [3*CHAN_W-1:0] color_b,
  input  logic [3*CHAN_W-1:0] tile_size,
  input  logic [CHAN_W-1:0]   grad_step,
  input  logic                de_in,
  input  logic                hs_in,
  input  logic                vs_in,
  input  logic [3*CHAN_W-1:0] vid_in,
  output logic [3*CHAN_W-1:0] pix_out,
  output logic                de_out,
  output logic                hs_out,
  output logic                vs_out
);
  localparam int NCH = 3;
  localparam int PW  = NCH * CHAN_W;

  raster_ev_t        ev;
  logic              use_b;
  logic [CHAN_W-1:0] ramp;
  logic [PW-1:0]     ramp_px;
  logic [PW-1:0]     pix_d;
  src_e              src;

  pg_raster_events u_ev (
    .clk   (clk),
    .rst_n (rst_n),
    .de_in (de_in),
    .hs_in (hs_in),
    .vs_in (vs_in),
    .ev    (ev),
    .de_q  (de_out),
    .hs_q  (hs_out),
    .vs_q  (vs_out)
  );

  pg_tile_gen #(.SIZE_W(CHAN_W)) u_tile (
    .clk     (clk),
    .rst_n   (rst_n),
    .de_in   (de_in),
    .ev      (ev),
    .width_a (tile_size[CHAN_W-1:0]),
    .width_b (tile_size[2*CHAN_W-1:CHAN_W]),
    .band_h  (tile_size[3*CHAN_W-1:2*CHAN_W]),
    .use_b   (use_b)
  );

  pg_ramp_gen #(.STEP_W(CHAN_W)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .de_in (de_in),
    .ev    (ev),
    .step  (grad_step),
    .level (ramp)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_grey
    assign ramp_px[g*CHAN_W +: CHAN_W] = ramp;
  end

  always_comb begin
    if (chk_en)       src = SRC_CHK;
    else if (grad_en) src = SRC_RAMP;
    else              src = SRC_PASS;
  end

  always_comb begin
    pix_d = '0;
    if (de_in) begin
      unique case (src)
        SRC_CHK:  pix_d = use_b ? color_b : color_a;
        SRC_RAMP: pix_d = ramp_px;
        default:  pix_d = vid_in;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pix_d;
  end
endmodule

// File: rtl/pg_pattern_src_sva.sv
module pg_pattern_src_sva #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_en,
  input logic          grad_en,
  input logic [PW-1:0] color_a,
  input logic [PW-1:0] color_b,
  input logic          de_in,
  input logic          hs_in,
  input logic          vs_in,
  input logic [PW-1:0] vid_in,
  input logic [PW-1:0] pix_out,
  input logic          de_out,
  input logic          hs_out,
  input logic          vs_out
);
  localparam int C = PW / 3;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_blank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> pix_out == '0);

  p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (de_out == $past(de_in) && hs_out == $past(hs_in) && vs_out == $past(vs_in)));

  p_chk_colour_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && de_out && $past(chk_en))
      |-> (pix_out == $past(color_a) || pix_out == $past(color_b)));

  p_ramp_grey_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && de_out && $past(grad_en && !chk_en))
      |-> (pix_out[C-1:0] == pix_out[2*C-1:C] && pix_out[C-1:0] == pix_out[PW-1:2*C]));

  p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && de_out && $past(!grad_en && !chk_en)) |-> pix_out == $past(vid_in));
endmodule

bind pg_pattern_src pg_pattern_src_sva #(.PW(PW)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .chk_en  (chk_en),
  .grad_en (grad_en),
  .color_a (color_a),
  .color_b (color_b),
  .de_in   (de_in),
  .hs_in   (hs_in),
  .vs_in   (vs_in),
  .vid_in  (vid_in),
  .pix_out (pix_out),
  .de_out  (de_out),
  .hs_out  (hs_out),
  .vs_out  (vs_out)
);

// File: tb/pg_pattern_src_bench.sv
module pg_pattern_src_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACT   = 20;
  localparam int LINES = 7;
  localparam logic [23:0] CA = 24'hFECC00;
  localparam logic [23:0] CB = 24'h006AA7;
  localparam int NCFG = 8;
  // {mode[1:0] (bit0 checker, bit1 ramp), width A, width B, band height, step}
  localparam logic [33:0] TBL [0:NCFG-1] = '{
    {2'b01, 8'd3, 8'd2, 8'd2, 8'd0},
    {2'b01, 8'd1, 8'd4, 8'd1, 8'd0},
    {2'b01, 8'd0, 8'd0, 8'd0, 8'd0},
    {2'b10, 8'd0, 8'd0, 8'd0, 8'h10},
    {2'b10, 8'd0, 8'd0, 8'd0, 8'h25},
    {2'b00, 8'd0, 8'd0, 8'd0, 8'd0},
    {2'b11, 8'd5, 8'd3, 8'd3, 8'h10},
    {2'b01, 8'd60, 8'd60, 8'd60, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, grad_en = 1'b0;
  logic [23:0] color_a = CA, color_b = CB, tile_size = '0, vid_in = '0;
  logic [7:0] grad_step = '0;
  logic de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic [23:0] pix_out;
  logic de_out, hs_out, vs_out;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_pattern_src u_pg_pattern_src (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .grad_en(grad_en),
    .color_a(color_a), .color_b(color_b), .tile_size(tile_size),
    .grad_step(grad_step), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .vid_in(vid_in), .pix_out(pix_out), .de_out(de_out), .hs_out(hs_out),
    .vs_out(vs_out)
  );

  function automatic logic [23:0] model(input logic [1:0] md, input int x, input int y,
                                        input int wa, input int wb, input int h,
                                        input int stp, input logic [23:0] vid);
    int ea, eb, eh, c, rem, w;
    logic [7:0] g;
    ea = (wa == 0) ? 1 : wa;
    eb = (wb == 0) ? 1 : wb;
    eh = (h == 0) ? 1 : h;
    if (md[0]) begin
      c = (y / eh) % 2;
      rem = x;
      for (int k = 0; k < 64; k++) begin
        w = c ? eb : ea;
        if (rem >= w) begin
          rem = rem - w;
          c = 1 - c;
        end
      end
      return c ? CB : CA;
    end else if (md[1]) begin
      g = 8'((x * stp) % 256);
      return {g, g, g};
    end
    return vid;
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check the registered result one edge later.
  task automatic step(input logic de, input logic hs, input logic vs,
                      input logic [23:0] vid, input logic [23:0] exp, input string req);
    de_in = de; hs_in = hs; vs_in = vs; vid_in = vid;
    @(posedge clk);
    @(negedge clk);
    check(req, pix_out, de ? exp : 24'h0);
    check("R10", {21'h0, de_out, hs_out, vs_out}, {21'h0, de, hs, vs});
  endtask

  task automatic run_frame(input logic [1:0] md, input int wa, input int wb,
                           input int h, input int stp, input string req);
    logic [23:0] v;
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, 24'h0, 24'h0, "R9");
    for (int y = 0; y < LINES; y++) begin
      step(1'b0, 1'b1, 1'b0, 24'h0, 24'h0, "R9");
      step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0, "R9");
      step(1'b0, 1'b0, 1'b0, 24'hFFFFFF, 24'h0, "R9");
      for (int x = 0; x < ACT; x++) begin
        v = {8'(x), 8'(y), 8'hA5};
        step(1'b1, 1'b0, 1'b0, v, model(md, x, y, wa, wb, h, stp, v), req);
      end
      step(1'b0, 1'b0, 1'b0, 24'h123456, 24'h0, "R9");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    string req;
    logic [1:0] md;
    // R1: reset state, with activity on the inputs
    chk_en = 1'b1; tile_size = 24'h010101;
    @(negedge clk);
    de_in = 1'b1; hs_in = 1'b1; vs_in = 1'b1; vid_in = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    check("R1", {pix_out}, 24'h0);
    check("R1", {21'h0, de_out, hs_out, vs_out}, 24'h0);
    de_in = 1'b0; hs_in = 1'b0; vs_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {pix_out}, 24'h0);
    check("R1", {21'h0, de_out, hs_out, vs_out}, 24'h0);

    // Table walk: two frames per configuration
    for (int i = 0; i < NCFG; i++) begin
      md = TBL[i][33:32];
      chk_en = md[0];
      grad_en = md[1];
      tile_size = {TBL[i][15:8], TBL[i][23:16], TBL[i][31:24]};
      grad_step = TBL[i][7:0];
      case (md)
        2'b01: req = (TBL[i][31:24] == 0) ? "R5 checker zero size" : "R2 R3 R4 checker";
        2'b10: req = "R6 ramp";
        2'b00: req = "R7 passthrough";
        default: req = "R8 both enables";
      endcase
      for (int f = 0; f < 2; f++)
        run_frame(md, int'(TBL[i][31:24]), int'(TBL[i][23:16]), int'(TBL[i][15:8]),
                  int'(TBL[i][7:0]), req);
    end

    // R1: reset asserted in the middle of active video clears the output
    chk_en = 1'b0; grad_en = 1'b0;
    de_in = 1'b1; vid_in = 24'hABCDEF;
    @(negedge clk);
    check("R7", pix_out, 24'hABCDEF);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", pix_out, 24'h0);
    check("R1", {23'h0, de_out}, 24'h0);
    de_in = 1'b0;
    rst_n = 1'b1;

    // R4: after reset, a new frame starts on A even with a mid-band history
    chk_en = 1'b1; tile_size = {8'd1, 8'd2, 8'd2};
    run_frame(2'b01, 2, 2, 1, 0, "R4 R3 after reset");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule